// File: doc/BRIEF.md
# Indexed effective-address calculator

This block works out a 32-bit operand address from a base value and a 16-bit index extension word. On `start` it decodes the extension word and reads one index register from a 16-entry register file. It then takes one of two paths. The short path adds the base, a signed 8-bit displacement and the index, and finishes in one cycle. The long path can suppress the base or the index. It can also pull displacement words from the instruction stream and make one memory-indirect 32-bit read before it forms the result.

A mode pin, `no_scale`, makes the block behave like an older core. The index is never scaled, and the long path is never taken. Each instruction word the block accepts moves the program counter on by 2 bytes, so a long displacement moves it on by 4. Instruction words arrive on a valid/ready stream. The block holds `ifetch_ready` high only in the cycles where it wants a word. A word counts as taken only in a cycle where both `ifetch_valid` and `ifetch_ready` are high, and the source may stall for any number of cycles.

The memory read has two valid/ready channels: a request channel and a response channel. The request holds `mrd_addr` steady until it is accepted. `mrd_rsp_ready` is high only while the block waits for the read data. The result appears with a single-cycle `done` pulse.

Top module: `idx_ea_calc`

## Requirements
- R1: `idx_sel` equals extension bits 15:12. Values 0–7 name data registers and 8–15 name address registers. The value read back on `idx_data` in the `start` cycle is the index used for the operation.
- R2: When extension bit 11 is 0, the index is the low 16 bits of the register, sign-extended to 32 bits. When bit 11 is 1, the whole 32-bit register is the index.
- R3: When `no_scale` is 0, the index is shifted left by extension bits 10:9 (×1, ×2, ×4 or ×8). When `no_scale` is 1, bits 10:9 have no effect.
- R4: The short path is taken when bit 8 is 0 or `no_scale` is 1. The result is base + sign-extended bits 7:0 + index. `done` rises in the cycle after `start`, and no instruction word or memory read is requested.
- R5: On the long path (bit 8 = 1), bit 7 = 1 replaces the base with zero and bit 6 = 1 replaces the index with zero.
- R6: On the long path, bits 5:4 select the base displacement:
  - 10: one instruction word, sign-extended.
  - 11: two instruction words, the first being the upper half.
  - 00 or 01: zero, with no word fetched.
- R7: After any base displacement, bits 1:0 select the outer displacement:
  - 10: one sign-extended word.
  - 11: two words, upper half first.
  - 00 or 01: zero, with no fetch.
- R8: Bit 2 = 0 adds the index before any indirection. Bit 2 = 1 adds it after. When bits 1:0 are nonzero, the intermediate address is read as a 32-bit value on the memory port, and the result is that value + the post-index (when bit 2 = 1) + the outer displacement.
- R9: An instruction word is consumed only in a cycle with `ifetch_valid` and `ifetch_ready` both high. A pending memory request keeps `mrd_valid` high and `mrd_addr` stable until `mrd_ready` is high. The block never asks for an instruction word and memory in the same cycle.
- R10: `done` is high for exactly one cycle, with the result on `ea_out`. A `start` that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; honoured only while idle |
| no_scale | input | 1 | Older-core mode: no scaling, short path only |
| base_in | input | 32 | Base address value |
| ext_word | input | 16 | Extension word |
| idx_sel | output | 4 | Register-file read index |
| idx_data | input | 32 | Register-file read data |
| ifetch_valid | input | 1 | Instruction word available |
| ifetch_ready | output | 1 | Block takes an instruction word |
| ifetch_word | input | 16 | Instruction word |
| mrd_valid | output | 1 | Memory read request valid |
| mrd_ready | input | 1 | Memory read request accepted |
| mrd_addr | output | 32 | Memory read address |
| mrd_rsp_valid | input | 1 | Read data valid |
| mrd_rsp_ready | output | 1 | Block takes read data |
| mrd_rsp_data | input | 32 | Read data |
| done | output | 1 | Result valid, one cycle |
| ea_out | output | 32 | Computed address |

## Verification
The bench builds the block with its default 32-bit address width and the fixed 4-bit register select, which lets every extension-word field reach its real sign and carry boundaries. With 32 bits, sign-extended word and byte displacements wrap past zero. A ×8 scale of a full register overflows bit 31, and a negative 16-bit index reaches the upper half of the address.

The instruction-word source is held off for long stretches and the memory ready toggles every cycle, so every handshake state of the sequence is crossed under back-pressure.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_BD_HI,
    S_BD_LO,
    S_OD_HI,
    S_OD_LO,
    S_CALC,
    S_RD_REQ,
    S_RD_RSP,
    S_DONE
  } ea_state_t;

  // Displacement size codes shared by the base and outer fields
  localparam logic [1:0] DISP_WORD = 2'b10;
  localparam logic [1:0] DISP_LONG = 2'b11;

  typedef struct packed {
    logic [3:0] sel;
    logic       full;
    logic [1:0] shamt;
    logic       long_fmt;
    logic       base_off;
    logic       idx_off;
    logic [1:0] bd;
    logic [1:0] od;
    logic       post;
  } ext_fields_t;

endpackage

// File: rtl/idx_ea_decode.sv
module idx_ea_decode
  import idx_ea_pkg::*;
(
  input  logic [15:0] ext_word,
  input  logic        no_scale,
  output ext_fields_t fields
);

  logic unused_bit3;
  assign unused_bit3 = ext_word[3];

  always_comb begin
    fields.sel      = ext_word[15:12];
    fields.full     = ext_word[11];
    fields.shamt    = no_scale ? 2'd0 : ext_word[10:9];
    fields.long_fmt = ext_word[8] & ~no_scale;
    fields.base_off = ext_word[7];
    fields.idx_off  = ext_word[6];
    fields.bd       = ext_word[5:4];
    fields.post     = ext_word[2];
    fields.od       = ext_word[1:0];
  end

endmodule

// File: rtl/idx_ea_index.sv
module idx_ea_index #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] reg_val,
  input  logic              full,
  input  logic [1:0]        shamt,
  output logic [ADDR_W-1:0] index
);

  localparam int HALF_W = 16;

  logic [ADDR_W-1:0] widened;

  assign widened = full ? reg_val
                        : {{(ADDR_W-HALF_W){reg_val[HALF_W-1]}}, reg_val[HALF_W-1:0]};
  assign index   = widened << shamt;

endmodule

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
  import idx_ea_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_CNT = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       no_scale,
  input  logic [ADDR_W-1:0]          base_in,
  input  logic [15:0]                ext_word,
  output logic [$clog2(REG_CNT)-1:0] idx_sel,
  input  logic [ADDR_W-1:0]          idx_data,
  input  logic                       ifetch_valid,
  output logic                       ifetch_ready,
  input  logic [15:0]                ifetch_word,
  output logic                       mrd_valid,
  input  logic                       mrd_ready,
  output logic [ADDR_W-1:0]          mrd_addr,
  input  logic                       mrd_rsp_valid,
  output logic                       mrd_rsp_ready,
  input  logic [ADDR_W-1:0]          mrd_rsp_data,
  output logic                       done,
  output logic [ADDR_W-1:0]          ea_out
);

  localparam int SEL_W  = $clog2(REG_CNT);
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  ea_state_t         state;
  ext_fields_t       dec_f, fr;
  logic [ADDR_W-1:0] idx_now;
  logic [ADDR_W-1:0] acc, idx_r, outer;
  logic [WORD_W-1:0] hi_r;
  logic              post_r;
  logic              in_idle;
  logic              word_take;
  logic [ADDR_W-1:0] word_sext, long_val, short_sum;

  idx_ea_decode u_dec (
    .ext_word (ext_word),
    .no_scale (no_scale),
    .fields   (dec_f)
  );

  idx_ea_index #(.ADDR_W(ADDR_W)) u_idx (
    .reg_val (idx_data),
    .full    (dec_f.full),
    .shamt   (dec_f.shamt),
    .index   (idx_now)
  );

  assign idx_sel   = SEL_W'(dec_f.sel);
  assign in_idle   = (state == S_IDLE);
  assign word_take = ifetch_valid && ifetch_ready;
  assign word_sext = {{(ADDR_W-WORD_W){ifetch_word[WORD_W-1]}}, ifetch_word};
  assign long_val  = ADDR_W'({hi_r, ifetch_word});
  assign short_sum = base_in + {{(ADDR_W-BYTE_W){ext_word[BYTE_W-1]}}, ext_word[BYTE_W-1:0]}
                     + idx_now;

  function automatic ea_state_t od_entry(input logic [1:0] code);
    case (code)
      DISP_WORD: return S_OD_LO;
      DISP_LONG: return S_OD_HI;
      default:   return S_CALC;
    endcase
  endfunction

  function automatic ea_state_t bd_entry(input logic [1:0] bcode, input logic [1:0] ocode);
    case (bcode)
      DISP_WORD: return S_BD_LO;
      DISP_LONG: return S_BD_HI;
      default:   return od_entry(ocode);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      fr     <= '0;
      acc    <= '0;
      idx_r  <= '0;
      outer  <= '0;
      hi_r   <= '0;
      post_r <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            fr    <= dec_f;
            outer <= '0;
            if (!dec_f.long_fmt) begin
              acc    <= short_sum;
              idx_r  <= '0;
              post_r <= 1'b0;
              state  <= S_DONE;
            end else begin
              acc    <= dec_f.base_off ? '0 : base_in;
              idx_r  <= dec_f.idx_off ? '0 : idx_now;
              post_r <= dec_f.post;
              state  <= bd_entry(dec_f.bd, dec_f.od);
            end
          end
        end
        S_BD_HI: if (word_take) begin
          hi_r  <= ifetch_word;
          state <= S_BD_LO;
        end
        S_BD_LO: if (word_take) begin
          acc   <= acc + ((fr.bd == DISP_LONG) ? long_val : word_sext);
          state <= od_entry(fr.od);
        end
        S_OD_HI: if (word_take) begin
          hi_r  <= ifetch_word;
          state <= S_OD_LO;
        end
        S_OD_LO: if (word_take) begin
          outer <= (fr.od == DISP_LONG) ? long_val : word_sext;
          state <= S_CALC;
        end
        S_CALC: begin
          if (!post_r) acc <= acc + idx_r;
          state <= (fr.od != 2'b00) ? S_RD_REQ : S_DONE;
        end
        S_RD_REQ: if (mrd_ready) state <= S_RD_RSP;
        S_RD_RSP: if (mrd_rsp_valid) begin
          acc   <= mrd_rsp_data;
          state <= S_DONE;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ifetch_ready  = (state == S_BD_HI) || (state == S_BD_LO) ||
                    (state == S_OD_HI) || (state == S_OD_LO);
    mrd_valid     = (state == S_RD_REQ);
    mrd_addr      = acc;
    mrd_rsp_ready = (state == S_RD_RSP);
    done          = (state == S_DONE);
    ea_out        = acc + (post_r ? idx_r : '0) + outer;
  end

endmodule

// File: rtl/idx_ea_checker.sv
module idx_ea_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              no_scale,
  input logic [15:0]       ext_word,
  input logic              in_idle,
  input logic              ifetch_ready,
  input logic              mrd_valid,
  input logic              mrd_ready,
  input logic [ADDR_W-1:0] mrd_addr,
  input logic              mrd_rsp_ready,
  input logic              done
);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> in_idle);

  assert_short_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && start && (no_scale || !ext_word[8])) |=> done);

  assert_short_no_traffic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && start && (no_scale || !ext_word[8])) |=> (!ifetch_ready && !mrd_valid));

  assert_port_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ifetch_ready && (mrd_valid || mrd_rsp_ready)));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_valid && !mrd_ready) |=> (mrd_valid && $stable(mrd_addr)));

endmodule

bind idx_ea_calc idx_ea_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .no_scale      (no_scale),
  .ext_word      (ext_word),
  .in_idle       (in_idle),
  .ifetch_ready  (ifetch_ready),
  .mrd_valid     (mrd_valid),
  .mrd_ready     (mrd_ready),
  .mrd_addr      (mrd_addr),
  .mrd_rsp_ready (mrd_rsp_ready),
  .done          (done)
);

// File: tb/idx_ea_calc_bench.sv
module idx_ea_calc_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        no_scale = 1'b0;
  logic [31:0] base_in = '0;
  logic [15:0] ext_word = '0;
  logic [3:0]  idx_sel;
  logic [31:0] idx_data;
  logic        ifetch_valid, ifetch_ready;
  logic [15:0] ifetch_word;
  logic        mrd_valid, mrd_ready, mrd_rsp_valid, mrd_rsp_ready;
  logic [31:0] mrd_addr, mrd_rsp_data;
  logic        done;
  logic [31:0] ea_out;

  always #4 clk = ~clk;  // 125 MHz

  idx_ea_calc u_idx_ea_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .no_scale(no_scale),
    .base_in(base_in), .ext_word(ext_word), .idx_sel(idx_sel), .idx_data(idx_data),
    .ifetch_valid(ifetch_valid), .ifetch_ready(ifetch_ready), .ifetch_word(ifetch_word),
    .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
    .mrd_rsp_valid(mrd_rsp_valid), .mrd_rsp_ready(mrd_rsp_ready),
    .mrd_rsp_data(mrd_rsp_data), .done(done), .ea_out(ea_out)
  );

  int checks = 0;
  int failures = 0;
  int done_cnt = 0;
  int fetch_cnt = 0;

  logic [31:0] rf [16];
  assign idx_data = rf[idx_sel];

  // Instruction-word source with a gate for stalls
  logic [15:0] fw [16];
  logic [3:0]  fhead = '0;
  logic [3:0]  ftail = '0;
  logic        fetch_en = 1'b1;
  assign ifetch_valid = fetch_en && (fhead != ftail);
  assign ifetch_word  = fw[fhead];

  always @(posedge clk) begin
    if (ifetch_valid && ifetch_ready) begin
      fhead     <= fhead + 4'd1;
      fetch_cnt <= fetch_cnt + 1;
    end
  end

  // Memory model: request ready toggles, response one cycle later
  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h1357_9BDF;
  endfunction

  logic rdy_t = 1'b0;
  logic rsp_v = 1'b0;
  logic [31:0] rsp_d = '0;
  assign mrd_ready     = rdy_t;
  assign mrd_rsp_valid = rsp_v;
  assign mrd_rsp_data  = rsp_d;

  always @(posedge clk) begin
    rdy_t <= ~rdy_t;
    if (mrd_valid && mrd_ready) begin
      rsp_v <= 1'b1;
      rsp_d <= memf(mrd_addr);
    end else if (rsp_v && mrd_rsp_ready) begin
      rsp_v <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always @(negedge clk) begin
    if (rst_n && done) begin
      done_cnt++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected done", ea_out, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(ea_out == e, t, ea_out, e);
      end
    end
  end

  function automatic logic [31:0] sx16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] ref_ea(input logic [31:0] base, input logic [15:0] e,
                                         input bit leg, input logic [31:0] bdv,
                                         input logic [31:0] odv);
    logic [31:0] idx, b, o;
    idx = rf[e[15:12]];
    if (!e[11]) idx = sx16(idx[15:0]);
    if (!leg) idx = idx << e[10:9];
    if (leg || !e[8]) return base + {{24{e[7]}}, e[7:0]} + idx;
    b = e[7] ? 32'h0 : base;
    if (e[6]) idx = 32'h0;
    if (e[5:4] == 2'b10) b = b + sx16(bdv[15:0]);
    if (e[5:4] == 2'b11) b = b + bdv;
    o = 32'h0;
    if (e[1:0] == 2'b10) o = sx16(odv[15:0]);
    if (e[1:0] == 2'b11) o = odv;
    if (!e[2]) b = b + idx;
    if (e[1:0] != 2'b00) b = memf(b);
    if (e[2]) b = b + idx;
    return b + o;
  endfunction

  function automatic logic [15:0] mk_short(input logic [3:0] r, input logic full,
                                           input logic [1:0] sc, input logic [7:0] d);
    return {r, full, sc, 1'b0, d};
  endfunction

  function automatic logic [15:0] mk_long(input logic [3:0] r, input logic full,
                                          input logic [1:0] sc, input logic bs, input logic is,
                                          input logic [1:0] bd, input logic post,
                                          input logic [1:0] od);
    return {r, full, sc, 1'b1, bs, is, bd, 1'b0, post, od};
  endfunction

  task automatic push_word(input logic [15:0] w);
    fw[ftail] = w;
    ftail = ftail + 4'd1;
  endtask

  task automatic push_disp(input logic [1:0] code, input logic [31:0] v, inout int nw);
    if (code == 2'b10) begin push_word(v[15:0]); nw += 1; end
    if (code == 2'b11) begin push_word(v[31:16]); push_word(v[15:0]); nw += 2; end
  endtask

  task automatic launch(input logic [31:0] base, input logic [15:0] e, input bit leg,
                        input logic [31:0] bdv, input logic [31:0] odv, input string tag,
                        output int nw);
    nw = 0;
    if (!leg && e[8]) begin
      push_disp(e[5:4], bdv, nw);
      push_disp(e[1:0], odv, nw);
    end
    exp_q.push_back(ref_ea(base, e, leg, bdv, odv));
    tag_q.push_back(tag);
    base_in  = base;
    ext_word = e;
    no_scale = leg;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  task automatic run_op(input logic [31:0] base, input logic [15:0] e, input bit leg,
                        input logic [31:0] bdv, input logic [31:0] odv, input string tag);
    int nw, f0, d0;
    f0 = fetch_cnt;
    d0 = done_cnt;
    launch(base, e, leg, bdv, odv, tag, nw);
    while (done_cnt == d0) @(negedge clk);
    repeat (2) @(negedge clk);
    check((fetch_cnt - f0) == nw, {tag, " word count"}, 32'(fetch_cnt - f0), 32'(nw));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'h0101_0000 * i + 32'h10 * i;
    rf[3]  = 32'h0001_8004;  // negative low half
    rf[5]  = 32'h8765_4321;
    rf[13] = 32'h0000_0100;
    rf[10] = 32'hFFFF_0040;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R10 reset done", 32'(done), 32'h0);
    check(ifetch_ready == 1'b0, "R9 reset fetch idle", 32'(ifetch_ready), 32'h0);
    check(mrd_valid == 1'b0, "R9 reset read idle", 32'(mrd_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4: data register, sign-extended, scale x4, negative byte disp
    run_op(32'h0000_2000, mk_short(4'd3, 1'b0, 2'd2, 8'hFC), 1'b0, 0, 0, "R1 R2 R3 R4 short sext");
    // R1 R2 R3: address register 13, full index, x8
    run_op(32'h0010_0000, mk_short(4'd13, 1'b1, 2'd3, 8'h7F), 1'b0, 0, 0, "R1 R2 R3 short full");
    // R2: full index that overflows when scaled
    run_op(32'h0000_0010, mk_short(4'd5, 1'b1, 2'd1, 8'h00), 1'b0, 0, 0, "R2 R3 full scaled");
    // R3 R4: no_scale ignores scale bits and bit 8
    run_op(32'h0000_1000, mk_long(4'd3, 1'b0, 2'd3, 1'b0, 1'b0, 2'b11, 1'b0, 2'b11), 1'b1,
           32'h1111_2222, 0, "R3 R4 older mode");
    // R5 R6: both suppressed, negative word base displacement
    run_op(32'hDEAD_0000, mk_long(4'd5, 1'b1, 2'd0, 1'b1, 1'b1, 2'b10, 1'b0, 2'b00), 1'b0,
           32'h0000_FFF0, 0, "R5 R6 suppress word bd");
    // R6: long base displacement, pre-index, no indirection; source stalled
    fetch_en = 1'b0;
    fork
      begin repeat (5) @(negedge clk); fetch_en = 1'b1; end
    join_none
    run_op(32'h0000_0100, mk_long(4'd10, 1'b0, 2'd1, 1'b0, 1'b0, 2'b11, 1'b0, 2'b00), 1'b0,
           32'h1234_8000, 0, "R6 R9 long bd stalled");
    // R6: code 00 and 01 fetch nothing
    run_op(32'h0000_0444, mk_long(4'd13, 1'b1, 2'd0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00), 1'b0,
           32'hAAAA_AAAA, 0, "R6 bd 00");
    run_op(32'h0000_0444, mk_long(4'd13, 1'b1, 2'd0, 1'b0, 1'b0, 2'b01, 1'b0, 2'b01), 1'b0,
           32'hAAAA_AAAA, 0, "R6 R7 bd 01 od 01");
    // R7 R8: pre-indexed indirect, word outer disp
    run_op(32'h0040_0000, mk_long(4'd3, 1'b0, 2'd1, 1'b0, 1'b0, 2'b10, 1'b0, 2'b10), 1'b0,
           32'h0000_0020, 32'h0000_8001, "R7 R8 pre-indexed");
    // R7 R8: post-indexed indirect, long outer disp
    run_op(32'h0040_0000, mk_long(4'd5, 1'b1, 2'd2, 1'b0, 1'b0, 2'b11, 1'b1, 2'b11), 1'b0,
           32'h0001_0000, 32'hF000_0004, "R7 R8 post-indexed");
    // R8: post-index without indirection
    run_op(32'h0000_5000, mk_long(4'd10, 1'b1, 2'd0, 1'b0, 1'b0, 2'b00, 1'b1, 2'b00), 1'b0,
           0, 0, "R8 post no indirect");

    // R10: start during a stalled long operation is ignored
    begin
      int nw, f0, d0;
      fetch_en = 1'b0;
      f0 = fetch_cnt;
      d0 = done_cnt;
      launch(32'h0000_0800, mk_long(4'd1, 1'b1, 2'd0, 1'b0, 1'b0, 2'b10, 1'b0, 2'b00), 1'b0,
             32'h0000_0002, 0, "R10 first op", nw);
      repeat (2) @(negedge clk);
      base_in  = 32'h7777_0000;
      ext_word = mk_short(4'd2, 1'b1, 2'd0, 8'h01);
      start    = 1'b1;
      @(negedge clk);
      start    = 1'b0;
      repeat (2) @(negedge clk);
      check(done_cnt == d0, "R10 no done while stalled", 32'(done_cnt - d0), 32'h0);
      fetch_en = 1'b1;
      while (done_cnt == d0) @(negedge clk);
      repeat (6) @(negedge clk);
      check(done_cnt == d0 + 1, "R10 single done", 32'(done_cnt - d0), 32'h1);
      check((fetch_cnt - f0) == nw, "R10 word count", 32'(fetch_cnt - f0), 32'(nw));
    end

    check(exp_q.size() == 0, "R10 scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule